// File: doc/BRIEF.md
# Receive Descriptor Status Writer

This block sits behind a MAC receive path and keeps the receive side of a descriptor list up to date. For each descriptor it asks for three items: the ownership bit, the control word that holds both buffer sizes and the list-walk controls, and the link word. It then counts the incoming frame bytes into buffer 1 and then buffer 2. When the frame ends, or when the buffers are full, it produces the descriptor's first (status) word. That word returns ownership to software. It carries the byte count, the first-segment and last-segment marks and the frame's error and filter flags. It also carries a summary error bit.

A frame may span several descriptors. When a descriptor fills before the frame ends, the block looks ahead at the next descriptor before it closes the current one. If software owns that next descriptor, the frame cannot continue. The current descriptor is then closed as the last segment with the descriptor-error bit set, and the rest of the frame is drained. The list is walked either as a ring with a stride of 16 bytes and a wrap mark, or as a chain that follows the link word. Moving the data bytes, filtering and CRC are handled elsewhere. Their results reach this block as flags that arrive with the last byte.

Top module: `rxd_status_writer`

## Requirements
- R1: While reset is held, `desc_req` is 1 with `desc_addr` equal to `ring_base`, and `wb_valid`, `in_ready` and `desc_unavail` are 0.
- R2: A fetched descriptor with `desc_own`=0 holds `in_ready` at 0 and raises `desc_unavail`. The same address is polled again until the ownership bit reads 1, and then `desc_unavail` drops.
- R3: Each descriptor gets exactly one status write to its own base address, with bit 31 equal to 0. After the byte carrying `in_eof` is accepted, `wb_valid` is high in the very next cycle. Address and data hold steady while `wb_ready` is 0.
- R4: Bits 29:16 of the status word give the total byte count of the frame in the last-segment word. In an earlier word they give the running count of bytes placed so far.
- R5: Bit 9 is set in the word of the descriptor that received the first byte of the frame. Bit 8 is set in the word that closes the frame.
- R6: In `desc_w1`, bits 12:0 give the buffer-1 size and bits 28:16 give the buffer-2 size. The capacity is their sum. A descriptor of capacity 0 is written back at once with the running count, with neither bit 9 nor bit 8 set.
- R7: The `in_flags` bits, sampled with the end byte, map to status bits as follows: 0 (CRC) to 1, 1 (receive error) to 3, 2 (watchdog) to 4, 3 (late collision) to 6, 4 (giant/checksum) to 7, 5 (overflow) to 11, 6 (destination filter fail) to 30, 7 (source filter fail) to 13, 8 (VLAN) to 10, 10 (frame-type) to 5. They appear only in a last-segment word.
- R8: Bit 15 is the OR of status bits 1, 3, 4, 6, 7, 11 and 14.
- R9: Bit 12 (length error) is `in_flags[9]` gated off when `in_flags[10]` or `in_flags[0]` is set.
- R10: If a descriptor fills mid-frame and the next descriptor is not owned, the current word is written with bits 8, 14 and 15 set and the count reached so far. The remaining bytes are accepted with `in_ready`=1 and discarded until the end byte, and they cause no further write.
- R11: The next descriptor address is `desc_w3` when `desc_w1[14]` (chain) is set. Otherwise it is `ring_base` when `desc_w1[15]` (end of ring) is set. Otherwise it is the current address plus 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ring_base | input | ADDR_W | Address of the first descriptor of the list |
| desc_req | output | 1 | Descriptor fetch request |
| desc_addr | output | ADDR_W | Base address of the descriptor requested |
| desc_ack | input | 1 | Fetch data valid this cycle |
| desc_own | input | 1 | Ownership bit of the fetched descriptor (1 = this block) |
| desc_w1 | input | 32 | Control word: buffer sizes, end-of-ring, chain |
| desc_w3 | input | ADDR_W | Link word (next descriptor in chain mode) |
| in_valid | input | 1 | Byte valid |
| in_ready | output | 1 | Byte accepted when high with in_valid |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_flags | input | 11 | Frame flags, valid with in_eof |
| wb_valid | output | 1 | Status write request |
| wb_ready | input | 1 | Status write accepted |
| wb_addr | output | ADDR_W | Descriptor base address written |
| wb_data | output | 32 | Status word |
| desc_unavail | output | 1 | The descriptor at hand is owned by software |

## Verification
The write port of the design is in the very next cycle after the byte carrying `in_eof` is accepted. The bench samples `wb_valid` and `wb_addr` at the falling edge straight after that accepting edge. The ownership stall and its release take one fetch round trip, which is two clock edges, so the bench looks at `desc_unavail` and `in_ready` a few cycles after it changes the descriptor memory. A status word is checked in the bench's memory model only after the write handshake has had time to land. While `wb_ready` is held low, the bench checks that the write is pending and that the word in memory is untouched.

// File: rtl/rxd_pkg.sv
// Shared constants and state type for the receive status writer.
package rxd_pkg;
    localparam int FL_W  = 14;   // width of the byte-count field
    localparam int BSZ_W = 13;   // width of one buffer size field
    localparam int FLG_W = 11;   // number of frame flags

    // positions inside in_flags
    localparam int F_CRC   = 0;
    localparam int F_RXE   = 1;
    localparam int F_WDG   = 2;
    localparam int F_LCOL  = 3;
    localparam int F_GIANT = 4;
    localparam int F_OVF   = 5;
    localparam int F_DAF   = 6;
    localparam int F_SAF   = 7;
    localparam int F_VLAN  = 8;
    localparam int F_LEN   = 9;
    localparam int F_TYPE  = 10;

    // control word positions
    localparam int C_EOR   = 15;
    localparam int C_CHAIN = 14;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_RECV,
        ST_PEEK,
        ST_WB,
        ST_DROP
    } wr_state_e;
endpackage

// File: rtl/rxd_next_addr.sv
// Next descriptor address.
// Chain mode follows the link word; ring mode steps by STRIDE and wraps to
// the list base on the end-of-ring mark. Purely combinational.
module rxd_next_addr #(
    parameter int ADDR_W = 32,
    parameter int STRIDE = 16
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] link,
    input  logic              chain,
    input  logic              eor,
    output logic [ADDR_W-1:0] nxt
);
    // select successor address
    always_comb begin
        if (chain)
            nxt = link;
        else if (eor)
            nxt = base;
        else
            nxt = cur + ADDR_W'(STRIDE);
    end
endmodule

// File: rtl/rxd_byte_track.sv
// Byte accounting for one descriptor and one frame.
// Keeps the fill level of the current descriptor against its capacity,
// the running frame count, and whether this descriptor saw the first byte.
// Assumes 'beat' is only raised while fill is below capacity.
module rxd_byte_track
    import rxd_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [FL_W-1:0] load_cap,
    input  logic            beat,
    input  logic            beat_sof,
    input  logic            frame_end,
    output logic [FL_W-1:0] tot_q,
    output logic [FL_W-1:0] tot_nx,
    output logic            full_nx,
    output logic            fs_q,
    output logic            fs_nx
);
    logic [FL_W-1:0] fill_q;
    logic [FL_W-1:0] cap_q;

    assign tot_nx  = beat_sof ? FL_W'(1) : tot_q + FL_W'(1);
    assign full_nx = (fill_q + FL_W'(1)) == cap_q;
    assign fs_nx   = fs_q | beat_sof;

    // update fill level, capacity, first-byte mark and frame count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= '0;
            cap_q  <= '0;
            fs_q   <= 1'b0;
            tot_q  <= '0;
        end else begin
            if (load) begin
                fill_q <= '0;
                cap_q  <= load_cap;
                fs_q   <= 1'b0;
            end else if (beat) begin
                fill_q <= fill_q + FL_W'(1);
                fs_q   <= fs_nx;
            end
            if (frame_end)
                tot_q <= '0;
            else if (beat)
                tot_q <= tot_nx;
        end
    end

    // R6
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= cap_q);
endmodule

// File: rtl/rxd_status_fmt.sv
// Status word builder.
// Places count, segment marks, frame flags, descriptor error and summary
// bit; ownership (bit 31) is always returned as 0. Combinational.
module rxd_status_fmt
    import rxd_pkg::*;
(
    input  logic [FLG_W-1:0] flags,
    input  logic             use_flags,
    input  logic             ls,
    input  logic             fs,
    input  logic             de,
    input  logic [FL_W-1:0]  fl,
    output logic [31:0]      word
);
    // assemble the word field by field
    always_comb begin
        word        = '0;
        word[29:16] = fl;
        word[9]     = fs;
        word[8]     = ls;
        word[14]    = de;
        if (use_flags) begin
            word[30] = flags[F_DAF];
            word[13] = flags[F_SAF];
            word[11] = flags[F_OVF];
            word[10] = flags[F_VLAN];
            word[7]  = flags[F_GIANT];
            word[6]  = flags[F_LCOL];
            word[5]  = flags[F_TYPE];
            word[4]  = flags[F_WDG];
            word[3]  = flags[F_RXE];
            word[1]  = flags[F_CRC];
            word[12] = flags[F_LEN] & ~flags[F_TYPE] & ~flags[F_CRC];
        end
        word[15] = word[1] | word[3] | word[4] | word[6] | word[7]
                 | word[11] | word[14];
    end
endmodule

// File: rtl/rxd_status_writer.sv
// Receive descriptor status writer (top).
// Fetches a descriptor, counts frame bytes into its two buffers, looks
// ahead at the next descriptor when full mid-frame, and writes back the
// status word. Assumes well-formed frames (sof first, eof last) and a
// fetch responder that answers each request cycle independently.
module rxd_status_writer
    import rxd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int STRIDE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ring_base,
    output logic              desc_req,
    output logic [ADDR_W-1:0] desc_addr,
    input  logic              desc_ack,
    input  logic              desc_own,
    input  logic [31:0]       desc_w1,
    input  logic [ADDR_W-1:0] desc_w3,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [FLG_W-1:0]  in_flags,
    output logic              wb_valid,
    input  logic              wb_ready,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [31:0]       wb_data,
    output logic              desc_unavail
);
    wr_state_e         st;
    logic [ADDR_W-1:0] cur_q;
    logic [ADDR_W-1:0] nxt_q;
    logic [ADDR_W-1:0] nxt_addr;
    logic [31:0]       data_q;
    logic              drop_q;
    logic              unavail_q;

    logic [FL_W-1:0]   cap_w;
    logic              unused_w1_rsvd;
    logic              trk_load, trk_beat, frame_end;
    logic [FL_W-1:0]   tot_q, tot_nx;
    logic              full_nx, fs_q, fs_nx;

    logic              f_use, f_ls, f_fs, f_de;
    logic [FL_W-1:0]   f_fl;
    logic [31:0]       f_word;

    assign cap_w = {1'b0, desc_w1[BSZ_W-1:0]} + {1'b0, desc_w1[16+BSZ_W-1:16]};
    assign unused_w1_rsvd = ^desc_w1[31:29];

    assign desc_req     = (st == ST_FETCH) || (st == ST_PEEK);
    assign desc_addr    = (st == ST_PEEK) ? nxt_q : cur_q;
    assign in_ready     = (st == ST_RECV) || (st == ST_DROP);
    assign wb_valid     = (st == ST_WB);
    assign wb_addr      = cur_q;
    assign wb_data      = data_q;
    assign desc_unavail = unavail_q;

    assign trk_load  = (st == ST_FETCH) && desc_ack && desc_own;
    assign trk_beat  = (st == ST_RECV) && in_valid;
    assign frame_end = in_valid && in_ready && in_eof;

    rxd_next_addr #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_next (
        .cur   (cur_q),
        .base  (ring_base),
        .link  (desc_w3),
        .chain (desc_w1[C_CHAIN]),
        .eor   (desc_w1[C_EOR]),
        .nxt   (nxt_addr)
    );

    rxd_byte_track u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (trk_load),
        .load_cap  (cap_w),
        .beat      (trk_beat),
        .beat_sof  (in_sof),
        .frame_end (frame_end),
        .tot_q     (tot_q),
        .tot_nx    (tot_nx),
        .full_nx   (full_nx),
        .fs_q      (fs_q),
        .fs_nx     (fs_nx)
    );

    // choose the inputs of the status word for the current state
    always_comb begin
        f_use = 1'b0;
        f_ls  = 1'b0;
        f_de  = 1'b0;
        f_fs  = fs_q;
        f_fl  = tot_q;
        case (st)
            ST_RECV: begin
                f_use = 1'b1;
                f_ls  = 1'b1;
                f_fs  = fs_nx;
                f_fl  = tot_nx;
            end
            ST_PEEK: begin
                f_ls = ~desc_own;
                f_de = ~desc_own;
            end
            ST_FETCH: f_fs = 1'b0;
            default: ;
        endcase
    end

    rxd_status_fmt u_fmt (
        .flags     (in_flags),
        .use_flags (f_use),
        .ls        (f_ls),
        .fs        (f_fs),
        .de        (f_de),
        .fl        (f_fl),
        .word      (f_word)
    );

    // control sequence: fetch, receive, look ahead, write back, drain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_FETCH;
            cur_q     <= ring_base;
            nxt_q     <= ring_base;
            data_q    <= '0;
            drop_q    <= 1'b0;
            unavail_q <= 1'b0;
        end else begin
            case (st)
                ST_FETCH: if (desc_ack) begin
                    if (!desc_own) begin
                        unavail_q <= 1'b1;
                    end else begin
                        unavail_q <= 1'b0;
                        nxt_q     <= nxt_addr;
                        if (cap_w == '0) begin
                            data_q <= f_word;
                            st     <= ST_WB;
                        end else begin
                            st <= ST_RECV;
                        end
                    end
                end
                ST_RECV: if (in_valid) begin
                    if (in_eof) begin
                        data_q <= f_word;
                        st     <= ST_WB;
                    end else if (full_nx) begin
                        st <= ST_PEEK;
                    end
                end
                ST_PEEK: if (desc_ack) begin
                    data_q <= f_word;
                    drop_q <= ~desc_own;
                    st     <= ST_WB;
                end
                ST_WB: if (wb_ready) begin
                    cur_q  <= nxt_q;
                    drop_q <= 1'b0;
                    st     <= drop_q ? ST_DROP : ST_FETCH;
                end
                ST_DROP: if (in_valid && in_eof) begin
                    st <= ST_FETCH;
                end
                default: st <= ST_FETCH;
            endcase
        end
    end

    // R3
    wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && !wb_ready |=> wb_valid && $stable(wb_data) && $stable(wb_addr));
    // R3
    own_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> !wb_data[31]);
    // R2
    stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        desc_unavail |-> !in_ready);
    // R10
    de_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && wb_data[14] |-> wb_data[8] && wb_data[15]);
    // R2
    unavail_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(desc_unavail) |-> desc_req);
endmodule

// File: tb/rxd_status_writer_tb.sv
// Directed bench for the receive status writer; descriptor memory model
// at 0x100..0x1FF, one task per scenario.
module rxd_status_writer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BASE = 32'h100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        desc_req, desc_ack = 1'b0, desc_own = 1'b0;
    logic [31:0] desc_addr, desc_w1 = '0, desc_w3 = '0;
    logic        in_valid = 1'b0, in_ready, in_sof = 1'b0, in_eof = 1'b0;
    logic [10:0] in_flags = '0;
    logic        wb_valid, wb_ready = 1'b1;
    logic [31:0] wb_addr, wb_data;
    logic        desc_unavail;

    logic [31:0] mem [64];
    int          n_chk = 0;
    int          n_bad = 0;
    int          n_wr  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxd_status_writer dut_i (
        .clk(clk), .rst_n(rst_n), .ring_base(BASE),
        .desc_req(desc_req), .desc_addr(desc_addr), .desc_ack(desc_ack),
        .desc_own(desc_own), .desc_w1(desc_w1), .desc_w3(desc_w3),
        .in_valid(in_valid), .in_ready(in_ready), .in_sof(in_sof),
        .in_eof(in_eof), .in_flags(in_flags),
        .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr),
        .wb_data(wb_data), .desc_unavail(desc_unavail)
    );

    function automatic int ix(input logic [31:0] a);
        return int'((a - BASE) >> 2) & 63;
    endfunction

    // fetch responder: answers the request seen at each falling edge
    always @(negedge clk) begin
        desc_ack <= desc_req;
        desc_own <= mem[ix(desc_addr)][31];
        desc_w1  <= mem[ix(desc_addr) + 1];
        desc_w3  <= mem[ix(desc_addr) + 3];
    end

    // status write capture
    always @(posedge clk) begin
        if (rst_n && wb_valid && wb_ready) begin
            mem[ix(wb_addr)] = wb_data;
            n_wr++;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put_desc(input int k, input logic own, input logic [31:0] w1,
                            input logic [31:0] w3);
        mem[4*k]     = {own, 31'h0};
        mem[4*k + 1] = w1;
        mem[4*k + 3] = w3;
    endtask

    task automatic send_frame(input int n, input logic [10:0] flg);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1;
            in_sof   = (i == 0);
            in_eof   = (i == n - 1);
            in_flags = (i == n - 1) ? flg : '0;
            while (!in_ready) @(negedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_flags = '0;
    endtask

    task automatic settle();
        repeat (12) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 desc_req", {31'h0, desc_req}, 32'h1);
        chk("R1 desc_addr", desc_addr, BASE);
        chk("R1 wb_valid", {31'h0, wb_valid}, 32'h0);
        chk("R1 in_ready", {31'h0, in_ready}, 32'h0);
        chk("R1 desc_unavail", {31'h0, desc_unavail}, 32'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_single();
        send_frame(20, '0);
        chk("R3 wb_valid after eof", {31'h0, wb_valid}, 32'h1);
        chk("R3 wb_addr", wb_addr, BASE);
        settle();
        chk("R4 R5 single frame word", mem[0], 32'h0014_0300);
    endtask

    task automatic t_flags();
        // crc, da fail, vlan, len err: LE gated by crc
        send_frame(30, 11'b011_0100_0001);
        settle();
        chk("R7 R8 R9 frame B", mem[4],
            (32'd1 << 30) | (32'd30 << 16) | 32'h8000 | 32'h0400 | 32'h0300 | 32'h2);
        // len err, sa fail, ovf, rx err: LE shown; write held off
        wb_ready = 1'b0;
        send_frame(12, 11'b010_1010_0010);
        repeat (3) @(negedge clk);
        chk("R3 write pending", {31'h0, wb_valid}, 32'h1);
        chk("R3 word untouched while held", mem[8], 32'h8000_0000);
        wb_ready = 1'b1;
        settle();
        chk("R7 R8 R9 frame C", mem[8],
            (32'd12 << 16) | 32'h1000 | 32'h2000 | 32'h0800 | 32'h0008 | 32'h8000 | 32'h0300);
        // len err with type bit, giant, late collision, watchdog
        send_frame(5, 11'b110_0001_1100);
        settle();
        chk("R7 R8 R9 frame D", mem[12],
            (32'd5 << 16) | 32'h0020 | 32'h0080 | 32'h0040 | 32'h0010 | 32'h8000 | 32'h0300);
    endtask

    task automatic t_stall_wrap();
        chk("R11 ring wrap address", desc_addr, BASE);
        chk("R2 unavail raised", {31'h0, desc_unavail}, 32'h1);
        chk("R2 input stalled", {31'h0, in_ready}, 32'h0);
        put_desc(0, 1'b1, 32'd10 | (32'd6 << 16), 32'h0);
        put_desc(1, 1'b1, 32'h0, 32'h0);
        put_desc(2, 1'b1, 32'd8 | (32'd8 << 16), 32'h0);
        put_desc(3, 1'b1, 32'd64 | (32'd1 << 15), 32'h0);
        repeat (4) @(negedge clk);
        chk("R2 unavail cleared", {31'h0, desc_unavail}, 32'h0);
        chk("R2 input open", {31'h0, in_ready}, 32'h1);
    endtask

    task automatic t_span();
        send_frame(40, '0);
        settle();
        chk("R4 R5 R6 span first", mem[0], 32'h0010_0200);
        chk("R6 zero capacity", mem[4], 32'h0010_0000);
        chk("R4 span middle", mem[8], 32'h0020_0000);
        chk("R4 R5 span last", mem[12], 32'h0028_0100);
    endtask

    task automatic t_trunc();
        int w0;
        put_desc(0, 1'b1, 32'd8, 32'h0);
        repeat (4) @(negedge clk);
        w0 = n_wr;
        send_frame(20, 11'h001);
        settle();
        chk("R10 truncated word", mem[0], 32'h0008_C300);
        chk("R10 single write", 32'(n_wr - w0), 32'd1);
        chk("R10 stall at next", desc_addr, BASE + 32'h10);
        chk("R2 R10 unavail after truncation", {31'h0, desc_unavail}, 32'h1);
    endtask

    task automatic t_chain();
        mem[48]     = 32'h8000_0000;
        mem[49]     = 32'd64;
        put_desc(1, 1'b1, 32'd4 | (32'd1 << 14), 32'h1C0);
        repeat (4) @(negedge clk);
        send_frame(10, '0);
        settle();
        chk("R11 R5 chained first", mem[4], 32'h0004_0200);
        chk("R11 R4 chained last", mem[48], 32'h000A_0100);
        chk("R11 stride after chain", desc_addr, 32'h1D0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        put_desc(0, 1'b1, 32'd64, 32'h0);
        put_desc(1, 1'b1, 32'd64, 32'h0);
        put_desc(2, 1'b1, 32'd64, 32'h0);
        put_desc(3, 1'b1, 32'd64 | (32'd1 << 15), 32'h0);
        @(negedge clk);
        t_reset();
        @(negedge clk);
        t_single();
        t_flags();
        t_stall_wrap();
        t_span();
        t_trunc();
        t_chain();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule